// File: doc/BRIEF.md
# Combined Waveform Selector

This block builds the 12-bit output word of a sound oscillator. Its inputs are the top twelve bits of the 24-bit phase accumulator, a 12-bit pulse width, a 12-bit noise word, four waveform enables (saw, triangle, pulse, noise) and a test bit. Each waveform is produced digitally. When several enables are set, each output bit is the AND of the selected waveforms' bits. This models the way a grounded selector input pulls a shared output line low.

The block also applies the per-waveform grounding of low bits. When saw and triangle are both on, the triangle fold is switched off. For the older chip variant, chosen by a parameter, the block raises a flag that tells the accumulator to clear its top bit whenever saw is selected and output bit 11 is low. The output word and the flag are registered together, so both appear one clock after the inputs.

Top module: `wave_combiner`

## Requirements
- R1: While `rst_n` is low at a rising edge, `wave_out` becomes 0 and `acc_msb_clr` becomes 0 at that edge.
- R2: With no enable set, `wave_out` is 0.
- R3: With only saw enabled, `wave_out` equals `phase_top`.
- R4: With only triangle enabled, `wave_out[11:1]` equals `phase_top[10:0]`, each bit XORed with `phase_top[11]`, and `wave_out[0]` is 0.
- R5: The pulse word is all ones when `test` is 1 or when `phase_top >= pulse_width` (unsigned), and all zeros otherwise.
- R6: The noise word is `noise_in` with bits 3:0 forced to 0.
- R7: With two or more enables set, each output bit is the AND of that bit in every selected waveform word.
- R8: When saw is enabled, the triangle fold is off, so triangle contributes `{phase_top[10:0],1'b0}`. Saw plus triangle therefore yields `phase_top & {phase_top[10:0],1'b0}`.
- R9: With pulse and triangle both enabled, `wave_out[0]` is 0.
- R10: With `OLD_MODEL=1`, `acc_msb_clr` is 1 exactly when saw was enabled and the `wave_out` produced in the same cycle has bit 11 at 0.
- R11: With `OLD_MODEL=0`, `acc_msb_clr` is always 0.
- R12: `wave_out` and `acc_msb_clr` reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_top | input | 12 | Accumulator bits 23:12 |
| pulse_width | input | 12 | Pulse compare threshold |
| noise_in | input | 12 | Noise register output word |
| test | input | 1 | Forces the pulse word to all ones |
| en_saw | input | 1 | Saw enable |
| en_trg | input | 1 | Triangle enable |
| en_pls | input | 1 | Pulse enable |
| en_nse | input | 1 | Noise enable |
| wave_out | output | 12 | Registered combined waveform |
| acc_msb_clr | output | 1 | Registered request to clear accumulator bit 23 |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One has `OLD_MODEL=1` and the other has `OLD_MODEL=0`, so the writeback flag is checked both where it must follow saw and bit 11 and where it must stay quiet. Both copies keep the default 12-bit width. This lets all sixteen enable combinations run, each with the test bit off and on. It also puts pulse widths equal to, one above, and below the phase value within reach, together with phase values whose top bit is set and whose top bit is clear.

// File: rtl/wave_pkg.sv
// Shared types for the combined waveform selector.
package wave_pkg;
    // Waveform enables, gathered into one bundle.
    typedef struct packed {
        logic saw;
        logic trg;
        logic pls;
        logic nse;
    } wave_en_t;
endpackage

// File: rtl/wave_gen.sv
// Generates the four single waveform words from the phase.
// Assumes: phase_top holds the upper OUT_W accumulator bits.
// The triangle fold is disabled by the caller when saw is enabled.
module wave_gen #(
    parameter int OUT_W = 12,
    parameter int NSE_GND = 4
) (
    input  logic [OUT_W-1:0] phase_top,
    input  logic [OUT_W-1:0] pulse_width,
    input  logic [OUT_W-1:0] noise_in,
    input  logic             test,
    input  logic             fold_en,
    output logic [OUT_W-1:0] saw_w,
    output logic [OUT_W-1:0] trg_w,
    output logic [OUT_W-1:0] pls_w,
    output logic [OUT_W-1:0] nse_w
);
    localparam int LOW_W = OUT_W - 1;

    logic [LOW_W-1:0] fold_mask;

    // Saw is the phase itself.
    assign saw_w = phase_top;

    // The fold mask copies the phase MSB into every lower bit when folding is on.
    assign fold_mask = {LOW_W{fold_en & phase_top[OUT_W-1]}};

    // Triangle: folded lower bits, shifted up, with the LSB grounded.
    assign trg_w = {phase_top[LOW_W-1:0] ^ fold_mask, 1'b0};

    // Pulse: all ones at or above the width, or whenever test is set.
    assign pls_w = (test || (phase_top >= pulse_width)) ? {OUT_W{1'b1}} : '0;

    // Noise: the lowest bits are grounded.
    assign nse_w = {noise_in[OUT_W-1:NSE_GND], {NSE_GND{1'b0}}};
endmodule

// File: rtl/wave_merge.sv
// Combines the selected waveform words by bitwise pulldown (AND).
// Assumes: the words come from wave_gen. With no enable set, the result is zero.
module wave_merge
    import wave_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input  wave_en_t         en,
    input  logic [OUT_W-1:0] saw_w,
    input  logic [OUT_W-1:0] trg_w,
    input  logic [OUT_W-1:0] pls_w,
    input  logic [OUT_W-1:0] nse_w,
    output logic [OUT_W-1:0] mixed
);
    logic any_en;
    logic [OUT_W-1:0] anded;

    assign any_en = en.saw | en.trg | en.pls | en.nse;

    // Each bit is pulled low by any selected waveform that has it at zero.
    for (genvar b = 0; b < OUT_W; b++) begin : g_bit
        logic pulled;
        assign pulled = (en.saw & ~saw_w[b]) | (en.trg & ~trg_w[b])
                      | (en.pls & ~pls_w[b]) | (en.nse & ~nse_w[b]);
        if (b == 0) begin : g_lsb
            // The pulse+triangle pairing pulls the LSB down hard.
            assign anded[b] = ~pulled & ~(en.pls & en.trg);
        end else begin : g_upper
            assign anded[b] = ~pulled;
        end
    end

    // No selection means no output lines are driven.
    assign mixed = any_en ? anded : '0;
endmodule

// File: rtl/wave_combiner.sv
// Top of the combined waveform selector: waveform generation, AND merge,
// output register and the older-variant accumulator MSB writeback flag.
// Assumes: synchronous active-low reset; outputs lag the inputs by one clock.
module wave_combiner
    import wave_pkg::*;
#(
    parameter int OUT_W = 12,
    parameter bit OLD_MODEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] phase_top,
    input  logic [OUT_W-1:0] pulse_width,
    input  logic [OUT_W-1:0] noise_in,
    input  logic             test,
    input  logic             en_saw,
    input  logic             en_trg,
    input  logic             en_pls,
    input  logic             en_nse,
    output logic [OUT_W-1:0] wave_out,
    output logic             acc_msb_clr
);
    localparam int MSB = OUT_W - 1;

    wave_en_t en;
    logic [OUT_W-1:0] saw_w, trg_w, pls_w, nse_w, mixed;
    logic clr_d;

    assign en = '{saw: en_saw, trg: en_trg, pls: en_pls, nse: en_nse};

    wave_gen #(.OUT_W(OUT_W), .NSE_GND(4)) u_gen (
        .phase_top(phase_top), .pulse_width(pulse_width), .noise_in(noise_in),
        .test(test), .fold_en(~en_saw),
        .saw_w(saw_w), .trg_w(trg_w), .pls_w(pls_w), .nse_w(nse_w)
    );

    wave_merge #(.OUT_W(OUT_W)) u_merge (
        .en(en), .saw_w(saw_w), .trg_w(trg_w), .pls_w(pls_w), .nse_w(nse_w),
        .mixed(mixed)
    );

    // Writeback request exists only in the older variant.
    if (OLD_MODEL) begin : g_old
        assign clr_d = en_saw & ~mixed[MSB];
    end else begin : g_new
        assign clr_d = 1'b0;
    end

    // Registers the output word and writeback flag together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_out    <= '0;
            acc_msb_clr <= 1'b0;
        end else begin
            wave_out    <= mixed;
            acc_msb_clr <= clr_d;
        end
    end

    assert_none_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_saw | en_trg | en_pls | en_nse) |=> wave_out == '0);

    assert_saw_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_saw && !en_trg && !en_pls && !en_nse) |=> wave_out == $past(phase_top));

    assert_noise_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_nse |=> wave_out[3:0] == 4'h0);

    assert_trg_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_trg |=> !wave_out[0]);

    assert_test_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (test && en_pls && !en_saw && !en_trg && !en_nse) |=> &wave_out);

    if (OLD_MODEL) begin : g_chk_old
        assert_clr_bit11_R10: assert property (@(posedge clk) disable iff (!rst_n)
            acc_msb_clr |-> !wave_out[MSB]);
    end else begin : g_chk_new
        assert_clr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_msb_clr);
    end
endmodule

// File: tb/wave_combiner_test.sv
module wave_combiner_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] ph = '0, pw = '0, nz = '0;
    logic tst = 1'b0, s = 1'b0, t = 1'b0, p = 1'b0, n = 1'b0;
    logic [11:0] out_old, out_new;
    logic clr_old, clr_new;
    int checks = 0, errors = 0;
    logic [11:0] exp_w = '0;
    logic exp_clr = 1'b0;
    string tag = "R1";

    always #4 clk = ~clk;

    wave_combiner #(.OUT_W(12), .OLD_MODEL(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .phase_top(ph), .pulse_width(pw), .noise_in(nz),
        .test(tst), .en_saw(s), .en_trg(t), .en_pls(p), .en_nse(n),
        .wave_out(out_old), .acc_msb_clr(clr_old));

    wave_combiner #(.OUT_W(12), .OLD_MODEL(1'b0)) uut_new (
        .clk(clk), .rst_n(rst_n), .phase_top(ph), .pulse_width(pw), .noise_in(nz),
        .test(tst), .en_saw(s), .en_trg(t), .en_pls(p), .en_nse(n),
        .wave_out(out_new), .acc_msb_clr(clr_new));

    // Behavioural model of the combined word, built from the requirements.
    function automatic logic [11:0] model(input logic [11:0] a, input logic [11:0] w,
                                          input logic [11:0] nw, input logic te,
                                          input logic es, input logic et,
                                          input logic ep, input logic en);
        int r, tri_v, low;
        bit any;
        r = 'hFFF; any = 0;
        if (es) begin r &= int'(a); any = 1; end
        if (et) begin
            low = int'(a) & 'h7FF;
            if (!es && a[11]) low ^= 'h7FF;
            tri_v = (low << 1) & 'hFFF;
            r &= tri_v; any = 1;
        end
        if (ep) begin
            if (!(te || a >= w)) r = 0;
            any = 1;
        end
        if (en) begin r &= int'(nw) & 'hFF0; any = 1; end
        if (ep && et) r &= 'hFFE;
        if (!any) r = 0;
        return 12'(r);
    endfunction

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: compare outputs from the previous drive, then drive new inputs.
    task automatic step(input logic [11:0] a, input logic [11:0] w, input logic [11:0] nw,
                        input logic [4:0] cfg);
        @(negedge clk);
        check({tag, "/R12 old"}, {clr_old, out_old}, {exp_clr, exp_w});
        check({tag, "/R11 new"}, {clr_new, out_new}, {1'b0, exp_w});
        ph = a; pw = w; nz = nw;
        {tst, s, t, p, n} = cfg;
        exp_w = model(a, w, nw, tst, s, t, p, n);
        exp_clr = s && !exp_w[11];
        case ({s, t, p, n})
            4'b0000: tag = "R2";
            4'b1000: tag = "R3";
            4'b0100: tag = "R4";
            4'b0010: tag = "R5";
            4'b0001: tag = "R6";
            4'b1100: tag = "R8";
            4'b0110: tag = "R9";
            default: tag = "R7";
        endcase
        if (s) tag = {tag, "/R10"};
    endtask

    initial begin
        logic [11:0] a, w;
        // R1: reset state, with enables active during reset.
        s = 1'b1; p = 1'b1; ph = 12'h123; pw = 12'h000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 old", {clr_old, out_old}, 13'h0);
        check("R1 new", {clr_new, out_new}, 13'h0);
        rst_n = 1'b1;
        exp_w = '0; exp_clr = 1'b0; tag = "R1";
        s = 1'b0; p = 1'b0;
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int k = 0; k < 6; k++) begin
                a = 12'($urandom);
                a[11] = k[0];
                case (k)
                    0: w = a;
                    1: w = (a == 12'hFFF) ? 12'hFFF : a + 12'd1;
                    2: w = 12'h000;
                    3: w = 12'hFFF;
                    default: w = 12'($urandom);
                endcase
                step(a, w, 12'($urandom), 5'(cfg));
            end
        end
        step(12'hFFF, 12'hFFF, 12'hFFF, 5'b01100);
        step(12'h7FF, 12'h800, 12'hFFF, 5'b00110);
        step(12'h000, 12'h001, 12'h000, 5'b00000);
        // Mid-run reset (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid old", {clr_old, out_old}, 13'h0);
        check("R1 mid new", {clr_new, out_new}, 13'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule